// File: doc/BRIEF.md
# Bus Listener Handshake and Address Front End

This block is the receive-side front end of an instrument sitting on a byte-wide parallel instrument bus. It follows the three-wire handshake. It raises ready-for-data when it can take a byte. It latches the seven data lines when the controller asserts data-valid. It answers with data-accepted and releases that acknowledge once data-valid drops. Bytes sent while the attention line is high are bus commands. A command equal to the configured device address makes the device addressed. The address-clear character `?` (0x3F) unaddresses it.

Bytes sent while attention is low are device characters. When the device is addressed, each one is passed to a downstream parser as a one-cycle strobe with the character. When it is not addressed, the byte is still acknowledged but goes nowhere. Ready-for-data stays low in two cases: while the parser reports it is busy, and while a programmed settling delay is counting down. The delay is loaded as BCD milliseconds and counted with an external one-millisecond tick.

The block also keeps a remote/local flag. Reset always leaves the device in local control, whatever the remote-enable line is doing.

Top module: `lsnFront`

## Requirements
- R1: After reset, ready-for-data is high, data-accepted is low, the character strobe is low, the device is not addressed and it is in local mode.
- R2: A byte is accepted on a clock edge where ready-for-data and data-valid are both high. From the next cycle, ready-for-data is low and data-accepted is high.
- R3: Data-accepted stays high while data-valid stays high. It goes low on the cycle after the first edge that sees data-valid low.
- R4: A byte accepted with attention high that equals `devAddr` (bits 6:0) makes the device addressed from the next cycle.
- R5: A byte accepted with attention high equal to 0x3F makes the device unaddressed. Any other command byte that is not the device address leaves the addressed state unchanged.
- R6: A byte accepted with attention low while the device is addressed appears on `charData`, with `charValid` high for exactly one cycle. That cycle is the same one in which data-accepted first goes high.
- R7: A byte accepted with attention low while the device is not addressed is acknowledged as in R2 and R3, but `charValid` stays low.
- R8: Command bytes (attention high) never raise `charValid`.
- R9: While `downBusy` is high, ready-for-data is low and no byte is accepted, even if data-valid is high.
- R10: A `delayStart` pulse loads `delayBcd` as a delay in milliseconds: bits 3:0 are units, 7:4 tens, 11:8 hundreds, and each digit is 0 to 9. Ready-for-data is then low until that many `msTick` pulses have been counted. A value of zero gives no hold.
- R11: The device becomes remote when it is addressed while remote-enable is high. It goes local on the cycle after remote-enable is seen low. After reset it is local even when remote-enable is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAtn | input | 1 | Attention: high marks a command byte |
| busRen | input | 1 | Remote enable from the controller |
| dataValid | input | 1 | Data-valid strobe, active high |
| busData | input | 7 | Data lines 1 to 7 |
| devAddr | input | 7 | Configured device address character |
| downBusy | input | 1 | Downstream parser still processing |
| delayStart | input | 1 | Load pulse for the settling delay |
| delayBcd | input | 12 | Delay in BCD milliseconds |
| msTick | input | 1 | One-cycle millisecond tick |
| rdyForData | output | 1 | Ready-for-data handshake |
| dataAccepted | output | 1 | Data-accepted handshake |
| charValid | output | 1 | One-cycle strobe of a forwarded character |
| charData | output | 7 | Forwarded character |
| isAddressed | output | 1 | Device is addressed as listener |
| isRemote | output | 1 | Device is under remote control |

## Verification
Two pairs of events can land in the same cycle. The first pair is the forwarding strobe and the rise of data-accepted. Every addressed character is meant to produce both together. A scoreboard queue holds the characters expected under R6 and R7. It is compared against each strobe sampled at the falling edge, and data-accepted is checked in that same sample. The second pair is the release of busy and a byte waiting on the bus. The bench holds data-valid high through a busy period and then drops busy. The byte must be taken on the very next edge: there is no acknowledge while busy, acknowledge in the cycle after release, and the character is in the queue.

// File: rtl/lsnPkg.sv
package lsnPkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_ACK  = 1'b1
  } lsnState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch the bus byte
    logic emit;     // forward it downstream
  } lsnStrobe_t;

endpackage

// File: rtl/lsnDatapath.sv
module lsnDatapath
  import lsnPkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DIGITS = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     busData,
  input  logic [ADDR_W-1:0]     devAddr,
  input  lsnStrobe_t            strobe,
  input  logic                  delayStart,
  input  logic [4*DIGITS-1:0]   delayBcd,
  input  logic                  msTick,
  output logic                  addrHit,
  output logic                  clrHit,
  output logic                  delayBusy,
  output logic                  charValid,
  output logic [ADDR_W-1:0]     charData
);

  localparam int CNT_W = $clog2(10**DIGITS);
  localparam logic [ADDR_W-1:0] CLR_CODE = ADDR_W'(63);

  logic [CNT_W-1:0] delayCnt;
  logic [CNT_W-1:0] delayLoad;

  assign addrHit   = (busData == devAddr);
  assign clrHit    = (busData == CLR_CODE);
  assign delayBusy = (delayCnt != '0);

  // BCD to binary, most significant digit first
  always_comb begin
    delayLoad = '0;
    for (int i = DIGITS - 1; i >= 0; i--) begin
      delayLoad = CNT_W'(delayLoad * CNT_W'(10)) + CNT_W'(delayBcd[i*4 +: 4]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      delayCnt <= '0;
    end else if (delayStart) begin
      delayCnt <= delayLoad;
    end else if (msTick && delayBusy) begin
      delayCnt <= delayCnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      charValid <= 1'b0;
      charData  <= '0;
    end else begin
      charValid <= strobe.emit;
      if (strobe.capture) charData <= busData;
    end
  end

  a_r10_delay_holds: assert property (@(posedge clk) disable iff (!rstN)
    (delayBusy && !msTick && !delayStart) |=> delayBusy);

  a_r6_char_matches_bus: assert property (@(posedge clk) disable iff (!rstN)
    strobe.emit |=> (charValid && charData == $past(busData)));

endmodule

// File: rtl/lsnCtrl.sv
module lsnCtrl
  import lsnPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busAtn,
  input  logic       busRen,
  input  logic       dataValid,
  input  logic       downBusy,
  input  logic       addrHit,
  input  logic       clrHit,
  input  logic       delayBusy,
  output lsnStrobe_t strobe,
  output logic       rdyForData,
  output logic       dataAccepted,
  output logic       isAddressed,
  output logic       isRemote
);

  lsnState_t state;
  logic      accept;

  assign rdyForData   = (state == ST_IDLE) && !downBusy && !delayBusy;
  assign dataAccepted = (state == ST_ACK);
  assign accept       = rdyForData && dataValid;

  assign strobe.capture = accept;
  assign strobe.emit    = accept && !busAtn && isAddressed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: if (accept)     state <= ST_ACK;
        ST_ACK:  if (!dataValid) state <= ST_IDLE;
        default:                 state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isAddressed <= 1'b0;
    end else if (accept && busAtn) begin
      if (addrHit)     isAddressed <= 1'b1;
      else if (clrHit) isAddressed <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isRemote <= 1'b0;
    end else if (!busRen) begin
      isRemote <= 1'b0;
    end else if (accept && busAtn && addrHit) begin
      isRemote <= 1'b1;
    end
  end

  a_r2_accept_handshake: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> (!rdyForData && dataAccepted));

  a_r3_dac_release: assert property (@(posedge clk) disable iff (!rstN)
    (dataAccepted && !dataValid) |=> !dataAccepted);

  a_r3_dac_hold: assert property (@(posedge clk) disable iff (!rstN)
    (dataAccepted && dataValid) |=> dataAccepted);

  a_r4_addr_set: assert property (@(posedge clk) disable iff (!rstN)
    (accept && busAtn && addrHit) |=> isAddressed);

  a_r11_local_on_ren_low: assert property (@(posedge clk) disable iff (!rstN)
    !busRen |=> !isRemote);

  a_r8_no_cmd_forward: assert property (@(posedge clk) disable iff (!rstN)
    busAtn |-> !strobe.emit);

endmodule

// File: rtl/lsnFront.sv
module lsnFront
  import lsnPkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DIGITS = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busAtn,
  input  logic                busRen,
  input  logic                dataValid,
  input  logic [ADDR_W-1:0]   busData,
  input  logic [ADDR_W-1:0]   devAddr,
  input  logic                downBusy,
  input  logic                delayStart,
  input  logic [4*DIGITS-1:0] delayBcd,
  input  logic                msTick,
  output logic                rdyForData,
  output logic                dataAccepted,
  output logic                charValid,
  output logic [ADDR_W-1:0]   charData,
  output logic                isAddressed,
  output logic                isRemote
);

  lsnStrobe_t strobe;
  logic       addrHit;
  logic       clrHit;
  logic       delayBusy;

  lsnCtrl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .busAtn       (busAtn),
    .busRen       (busRen),
    .dataValid    (dataValid),
    .downBusy     (downBusy),
    .addrHit      (addrHit),
    .clrHit       (clrHit),
    .delayBusy    (delayBusy),
    .strobe       (strobe),
    .rdyForData   (rdyForData),
    .dataAccepted (dataAccepted),
    .isAddressed  (isAddressed),
    .isRemote     (isRemote)
  );

  lsnDatapath #(
    .ADDR_W (ADDR_W),
    .DIGITS (DIGITS)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .busData    (busData),
    .devAddr    (devAddr),
    .strobe     (strobe),
    .delayStart (delayStart),
    .delayBcd   (delayBcd),
    .msTick     (msTick),
    .addrHit    (addrHit),
    .clrHit     (clrHit),
    .delayBusy  (delayBusy),
    .charValid  (charValid),
    .charData   (charData)
  );

  a_r6_strobe_with_dac: assert property (@(posedge clk) disable iff (!rstN)
    charValid |-> (dataAccepted && isAddressed));

  a_r9_busy_no_accept: assert property (@(posedge clk) disable iff (!rstN)
    (downBusy && !dataAccepted) |=> !dataAccepted);

endmodule

// File: tb/lsnFront_tb_top.sv
module lsnFront_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busAtn = 1'b0;
  logic        busRen = 1'b1;
  logic        dataValid = 1'b0;
  logic [6:0]  busData = '0;
  logic [6:0]  devAddr = 7'h25;
  logic        downBusy = 1'b0;
  logic        delayStart = 1'b0;
  logic [11:0] delayBcd = '0;
  logic        msTick = 1'b0;
  logic        rdyForData, dataAccepted, charValid, isAddressed, isRemote;
  logic [6:0]  charData;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [6:0] expQ[$];

  always #2 clk = ~clk;

  lsnFront dut_i (
    .clk(clk), .rstN(rstN), .busAtn(busAtn), .busRen(busRen),
    .dataValid(dataValid), .busData(busData), .devAddr(devAddr),
    .downBusy(downBusy), .delayStart(delayStart), .delayBcd(delayBcd),
    .msTick(msTick), .rdyForData(rdyForData), .dataAccepted(dataAccepted),
    .charValid(charValid), .charData(charData), .isAddressed(isAddressed),
    .isRemote(isRemote)
  );

  task automatic checkEq(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // driver: one full three-wire handshake, pushes expected characters
  task automatic sendByte(input logic atn, input logic [6:0] b, input bit fwd);
    while (!rdyForData) @(negedge clk);
    busAtn = atn; busData = b; dataValid = 1'b1;
    if (fwd) expQ.push_back(b);
    @(negedge clk);
    checkEq("R2", "rdy after accept", int'(rdyForData), 0);
    checkEq("R3", "dac after accept", int'(dataAccepted), 1);
    @(negedge clk);
    checkEq("R3", "dac held", int'(dataAccepted), 1);
    dataValid = 1'b0;
    @(negedge clk);
    checkEq("R3", "dac released", int'(dataAccepted), 0);
    busAtn = 1'b0;
  endtask

  // monitor: compare every forwarded character against the queue
  always @(negedge clk) begin
    if (rstN && charValid) begin
      if (expQ.size() == 0) begin
        total++; bad++;
        $display("FAIL R7 unexpected char actual=%0h expected=none", charData);
      end else begin
        logic [6:0] e;
        e = expQ.pop_front();
        checkEq("R6", "forwarded char", int'(charData), int'(e));
        checkEq("R6", "dac with strobe", int'(dataAccepted), 1);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog all actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state, R11 local despite remote-enable high
    checkEq("R1", "rdy", int'(rdyForData), 1);
    checkEq("R1", "dac", int'(dataAccepted), 0);
    checkEq("R1", "charValid", int'(charValid), 0);
    checkEq("R1", "addressed", int'(isAddressed), 0);
    checkEq("R11", "remote after reset", int'(isRemote), 0);

    // R7 unaddressed data is acked but dropped
    sendByte(1'b0, 7'h41, 1'b0);
    checkEq("R7", "still unaddressed", int'(isAddressed), 0);

    // R4 address match, R11 becomes remote
    sendByte(1'b1, 7'h25, 1'b0);
    checkEq("R4", "addressed", int'(isAddressed), 1);
    checkEq("R11", "remote", int'(isRemote), 1);

    // R6 forwarding several characters
    sendByte(1'b0, 7'h46, 1'b1);
    sendByte(1'b0, 7'h31, 1'b1);
    sendByte(1'b0, 7'h32, 1'b1);

    // R5/R8 other command keeps state, not forwarded
    sendByte(1'b1, 7'h14, 1'b0);
    checkEq("R5", "other cmd keeps addressed", int'(isAddressed), 1);

    // R9 busy blocks acceptance with a byte pending
    downBusy = 1'b1;
    busData = 7'h55; dataValid = 1'b1;
    @(negedge clk);
    checkEq("R9", "rdy while busy", int'(rdyForData), 0);
    repeat (3) @(negedge clk);
    checkEq("R9", "no dac while busy", int'(dataAccepted), 0);
    downBusy = 1'b0;
    expQ.push_back(7'h55);
    @(negedge clk);
    checkEq("R9", "accepted after release", int'(dataAccepted), 1);
    dataValid = 1'b0;
    @(negedge clk);
    @(negedge clk);

    // R10 delay of 12 ms
    delayBcd = 12'h012; delayStart = 1'b1;
    @(negedge clk);
    delayStart = 1'b0;
    checkEq("R10", "rdy after delay load", int'(rdyForData), 0);
    for (int i = 1; i <= 12; i++) begin
      msTick = 1'b1;
      @(negedge clk);
      msTick = 1'b0;
      checkEq("R10", "rdy during delay", int'(rdyForData), (i == 12) ? 1 : 0);
      @(negedge clk);
    end
    // R10 zero delay gives no hold
    delayBcd = 12'h000; delayStart = 1'b1;
    @(negedge clk);
    delayStart = 1'b0;
    checkEq("R10", "zero delay", int'(rdyForData), 1);

    // R11 remote-enable low forces local
    busRen = 1'b0;
    @(negedge clk);
    checkEq("R11", "local on ren low", int'(isRemote), 0);

    // R5 address clear, then R7 data dropped
    sendByte(1'b1, 7'h3F, 1'b0);
    checkEq("R5", "cleared", int'(isAddressed), 0);
    sendByte(1'b0, 7'h5A, 1'b0);
    repeat (2) @(negedge clk);
    checkEq("R6", "queue drained", expQ.size(), 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule